// File: doc/BRIEF.md
# Sixteen-Bit Carry-Select Adder with Increment Converter

This block adds two 16-bit unsigned operands and returns a 17-bit result. The top bit of the result is the carry-out. It is purely combinational, with no clock and no reset. The result follows the operands after the logic settles.

The operand is split into five slices of 2, 2, 3, 4 and 5 bits, counted from the least significant end. The lowest slice is a plain ripple adder. Each higher slice works out its partial sum once, with a ripple chain that assumes no incoming carry. An increment stage then turns that result into the version that assumes an incoming carry. The increment stage is used in place of a second ripple chain. The real carry from the slice below picks one of the two ready results, both the sum bits and the slice carry.

Top module: `csla_add16`

## Requirements
- R1: For every operand pair, `sum_o` equals the exact unsigned sum `a_i + b_i`, as a 17-bit value.
- R2: Bit 16 of `sum_o` is the carry-out. It is 1 exactly when `a_i + b_i` is 65536 or more, for example for 0xFFFF + 0x0001.
- R3: Zero plus zero gives zero on all 17 bits, and all-ones plus all-ones gives 0x1FFFE.
- R4: Result bits 1:0 come from a ripple slice with no carry input. They depend only on `a_i[1:0]` and `b_i[1:0]`, whatever the higher operand bits are.
- R5: The slices start at bits 2, 4, 7 and 11. A carry must cross each of these boundaries correctly. Example: `((1<<k)-1) + 1` gives `1<<k` for every boundary k.
- R6: In each selected slice, the carry-in-one result equals the carry-zero result plus one. Its slice carry is the carry-zero carry ORed with the AND of all the carry-zero sum bits.
- R7: Each selected slice passes on its carry-zero sum and carry when the carry from below is 0, and its carry-one sum and carry when that carry is 1. So a slice whose operand sum is all ones must ripple to the next slice exactly when the slice below produces a carry.
- R8: The block holds no state. After any change of the operands, the output reflects only the current operands, with no dependence on earlier ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand, unsigned |
| b_i | input | 16 | Second operand, unsigned |
| sum_o | output | 17 | Sum; bit 16 is the carry-out |

## Verification
Immediate assertions run whenever the logic re-evaluates, and they check three things:
- that each increment stage produces exactly its input plus one (R6);
- that each selected slice equals its operands plus its carry-in (R7);
- that the whole result matches the arithmetic sum (R1).

Some properties cannot be checked from inside the logic and are left to the bench's scenarios:
- the isolation of the lowest slice from the upper operand bits (R4);
- correct crossing of each specific slice boundary (R5);
- the lack of memory from one operand pair to the next (R8).

// File: rtl/csla_pkg.sv
package csla_pkg;
  localparam int NGRP = 5;

  function automatic int grp_width(input int g);
    case (g)
      0:       return 2;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int grp_lsb(input int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += grp_width(k);
    return acc;
  endfunction
endpackage

// File: rtl/csla_rca0.sv
// Ripple-carry slice with no carry input: half adder in the lowest stage.
module csla_rca0 #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:1] cy;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_half
      assign sum_o[i] = a_i[i] ^ b_i[i];
      assign cy[i+1]  = a_i[i] & b_i[i];
    end else begin : g_full
      assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
      assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/csla_bec.sv
// Increment converter: turns a carry-zero slice result into its carry-one form.
module csla_bec #(
  parameter int W = 4
) (
  input  logic [W-1:0] s0_i,
  input  logic         c0_i,
  output logic [W-1:0] s1_o,
  output logic         c1_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign s1_o[i] = ~s0_i[i];
    end else begin : g_up
      assign s1_o[i] = s0_i[i] ^ (&s0_i[i-1:0]);
    end
  end

  assign c1_o = c0_i | (&s0_i);

  // R6: the converted value is exactly the carry-zero value plus one
  always_comb begin
    p_plus_one_r6: assert ({c1_o, s1_o} == ({c0_i, s0_i} + (W+1)'(1)))
      else $error("R6 increment converter mismatch");
  end
endmodule

// File: rtl/csla_group.sv
// One selected slice: carry-zero ripple chain, increment converter, output select.
module csla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] s_zero, s_one;
  logic         c_zero, c_one;

  csla_rca0 #(.W(W)) u_rca (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (s_zero),
    .cout_o(c_zero)
  );

  csla_bec #(.W(W)) u_bec (
    .s0_i(s_zero),
    .c0_i(c_zero),
    .s1_o(s_one),
    .c1_o(c_one)
  );

  assign sum_o  = cin_i ? s_one : s_zero;
  assign cout_o = cin_i ? c_one : c_zero;

  // R7: selected slice equals operands plus the real carry from below
  always_comb begin
    p_slice_sum_r7: assert ({cout_o, sum_o} ==
                            ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("R7 slice select mismatch");
  end
endmodule

// File: rtl/csla_add16.sv
module csla_add16
  import csla_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH:0]   sum_o
);
  logic [NGRP:1] gcy;

  for (genvar g = 0; g < NGRP; g++) begin : g_slice
    localparam int GW = grp_width(g);
    localparam int LO = grp_lsb(g);
    if (g == 0) begin : g_base
      csla_rca0 #(.W(GW)) u_base (
        .a_i   (a_i[LO +: GW]),
        .b_i   (b_i[LO +: GW]),
        .sum_o (sum_o[LO +: GW]),
        .cout_o(gcy[g+1])
      );
    end else begin : g_sel
      csla_group #(.W(GW)) u_grp (
        .a_i   (a_i[LO +: GW]),
        .b_i   (b_i[LO +: GW]),
        .cin_i (gcy[g]),
        .sum_o (sum_o[LO +: GW]),
        .cout_o(gcy[g+1])
      );
    end
  end

  assign sum_o[WIDTH] = gcy[NGRP];

  // R1 / R2: the full result, including carry-out, is the arithmetic sum
  always_comb begin
    p_exact_sum_r1: assert (sum_o == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("R1 result mismatch");
    p_carry_out_r2: assert (sum_o[WIDTH] == ((32'(a_i) + 32'(b_i)) >= (32'd1 << WIDTH)))
      else $error("R2 carry-out mismatch");
  end
endmodule

// File: tb/csla_add16_bench.sv
module csla_add16_bench;
  localparam int W = 16;

  logic         clk;
  logic [W-1:0] a, b;
  logic [W:0]   s;
  int           n_cmp, n_bad;
  bit           done;

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz, used only to pace the stimulus

  csla_add16 u_csla_add16 (.a_i(a), .b_i(b), .sum_o(s));

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a, b, got, exp);
    end
  endtask

  // drive at the falling edge, sample midway to the rising edge
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    @(negedge clk);
    a = x; b = y;
    #5;
    check(req, s, {1'b0, x} + {1'b0, y});
  endtask

  task automatic t_extremes();
    apply(16'h0000, 16'h0000, "R3 zero");
    apply(16'hFFFF, 16'hFFFF, "R3 all-ones");
    check("R3 all-ones value", s, 17'h1FFFE);
    apply(16'hFFFF, 16'h0001, "R2 carry-out");
    check("R2 carry bit", {16'h0, s[W]}, 17'h1);
    apply(16'h8000, 16'h7FFF, "R2 no carry");
    check("R2 carry clear", {16'h0, s[W]}, 17'h0);
  endtask

  task automatic t_boundaries();
    int lsb[4] = '{2, 4, 7, 11};
    for (int k = 0; k < 4; k++) begin
      apply(16'((1 << lsb[k]) - 1), 16'h0001, "R5 boundary ripple");
      check("R5 boundary value", s, 17'(1 << lsb[k]));
      apply(16'(1 << (lsb[k] - 1)), 16'(1 << (lsb[k] - 1)), "R5 boundary generate");
    end
  endtask

  task automatic t_select();
    // slice 2..3 sums to all ones; carry from below toggles its selection
    apply(16'h000C, 16'h0000, "R7 no carry in");
    check("R7 value", s, 17'h0000C);
    apply(16'h000E, 16'h0002, "R7 carry in");
    check("R7 value", s, 17'h00010);
    apply(16'hF800, 16'h0400, "R6 converter top slice");
  endtask

  task automatic t_isolation();
    logic [1:0] ref_lo;
    apply(16'h0002, 16'h0003, "R4 base");
    ref_lo = s[1:0];
    for (int k = 0; k < 8; k++) begin
      apply(16'h0002 | 16'($urandom) & 16'hFFFC, 16'h0003 | 16'($urandom) & 16'hFFFC, "R4 sweep");
      check("R4 low bits", {15'h0, s[1:0]}, {15'h0, ref_lo});
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 3000; k++)
      apply(16'($urandom), 16'($urandom), "R1 random");
    // R8: alternate patterns, result must not carry history
    apply(16'hFFFF, 16'hFFFF, "R8 before");
    apply(16'h0001, 16'h0000, "R8 after");
    check("R8 value", s, 17'h00001);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    a = '0; b = '0;
    #5;
    check("R3 initial zero", s, 17'h0);
    t_extremes();
    t_boundaries();
    t_select();
    t_isolation();
    t_random();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule